// File: doc/BRIEF.md
# Complex Rotator Multiply-Accumulate with Growth Detector

This block takes a signed complex sample and multiplies it by a rotating (cos, sin) vector, as a quadrature mixer for up- or down-conversion. A two-bit control sets a shared arithmetic right shift that scales the sample before it is multiplied. Each product is kept at full width in a pair of product holding registers. The products can also be summed over a run of cycles. When the run is dumped, the sum is copied into a pair of accumulator holding registers, which gives an integrate-and-dump filter.

Every control input is registered once before it acts. A registered select picks which slice of which holding register pair appears on the two 20-bit output words. A registered format bit can turn those words into offset binary for a DAC. A block-floating-point detector reports a 2-bit code for how far the held values have grown into their guard bits. It can either show the present growth or keep the peak growth over a window.

Top module: `cmac_unit`

## Requirements
- R1: Controls are registered at each rising clock edge. At the next edge the sample registers load the shifted input words only if the registered `en_n_i` is 0. If it is 1 they keep their contents.
- R2: The registered `shift_i` value n (0 to 3) shifts both the real and the imaginary input right arithmetically by n bits before they are loaded.
- R3: The product holding registers take real = re*cos - im*sin and imag = re*sin + im*cos each cycle, as 36-bit signed values with no rounding. The operands are the loaded samples and the (cos, sin) words registered one edge earlier.
- R4: While registered `acc_i` is 1, each 24-bit accumulator adds the product holding value shifted right arithmetically by 17, and the accumulator holding registers keep their value. While it is 0, each accumulator loads that shifted term alone, and the holding registers take the accumulator value from before the edge.
- R5: The registered `sel_i` picks the word placed in the output registers. 0 gives accumulator holding bits 23:4, 1 gives product holding bits 35:16, 2 gives product holding bits 19:0, and 3 gives accumulator holding bits 19:0. The real output comes from the real registers and the imaginary output from the imaginary registers.
- R6: When registered `fmt_i` is 0, bit 19 of both output words is inverted. When it is 1, the words stay two's complement.
- R7: The growth code of a register compares four bits with its sign bit: bits 18:15 of a 24-bit accumulator holding register, or bits 33:30 of a 36-bit product holding register. The code is 3 if either of the upper two bits differs, else 2 if the third bit differs, else 1 if the lowest bit differs, else 0. The current code is the largest of the four registers' codes.
- R8: When registered `peak_i` is 0, `grow_o` shows the current code one edge later. On the first edge with registered `peak_i` at 1, `grow_o` takes the current code, which includes data already held. On later edges while it stays at 1, `grow_o` takes the larger of itself and the current code.
- R9: While `rst_n` is low, every register clears, both output words and `grow_o` read 0, the sample enable is inactive, accumulate mode is selected and the format is two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cos_i | input | 16 | Cosine word of the rotating vector, two's complement |
| sin_i | input | 16 | Sine word of the rotating vector, two's complement |
| re_i | input | 19 | Real input sample, two's complement |
| im_i | input | 19 | Imaginary input sample, two's complement |
| en_n_i | input | 1 | Sample load enable, active low |
| shift_i | input | 2 | Input right-shift amount |
| acc_i | input | 1 | 1 = accumulate, 0 = dump and restart |
| peak_i | input | 1 | 1 = track peak growth |
| fmt_i | input | 1 | 0 = offset-binary outputs |
| sel_i | input | 2 | Output word select |
| re_o | output | 20 | Real output word |
| im_o | output | 20 | Imaginary output word |
| grow_o | output | 2 | Growth code |

## Verification
The bench builds the block with its default widths: 19-bit samples, 16-bit trig words, 24-bit accumulators and a 17-bit accumulator scale. These widths keep full-scale products within reach of product bits 33:30. They also let a few accumulated full-scale terms reach accumulator bits 18:15, so every growth code from 0 to 3 occurs. A cycle-level reference model in the bench runs alongside the design, and a monitor compares both output words and the growth code every cycle. The stimulus includes enable gaps, all shift amounts, long and short accumulate runs, every select value, both formats, and peak windows that open while large values are already held.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

  typedef struct packed {
    logic       en_n;
    logic [1:0] sh;
    logic       acc;
    logic       peak;
    logic       fmt;
    logic [1:0] sel;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{en_n: 1'b1, sh: 2'd0, acc: 1'b1,
                                peak: 1'b0, fmt: 1'b1, sel: 2'd0};

  // growth code from a sign bit and the four examined guard bits
  function automatic logic [1:0] grow4(input logic sgn, input logic [3:0] nib);
    logic [1:0] code;
    code = 2'd0;
    for (int i = 0; i < 4; i++) begin
      if (nib[i] != sgn) code = (i >= 2) ? 2'd3 : 2'(i + 1);
    end
    return code;
  endfunction

  function automatic logic [1:0] max2(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cmac_in_stage.sv
module cmac_in_stage
  import cmac_pkg::*;
#(
  parameter int IN_W   = 19,
  parameter int TRIG_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctl_t                     ctl_i,
  input  logic signed [IN_W-1:0]   re_i,
  input  logic signed [IN_W-1:0]   im_i,
  input  logic signed [TRIG_W-1:0] cos_i,
  input  logic signed [TRIG_W-1:0] sin_i,
  output ctl_t                     ctl_o,
  output logic                     load_o,
  output logic signed [IN_W-1:0]   re_o,
  output logic signed [IN_W-1:0]   im_o,
  output logic signed [TRIG_W-1:0] cos_o,
  output logic signed [TRIG_W-1:0] sin_o
);

  ctl_t                     ctl_q;
  logic signed [IN_W-1:0]   re_q, im_q, re_sh, im_sh;
  logic signed [TRIG_W-1:0] cos_q, sin_q;

  // shared input shifter
  assign re_sh  = re_i >>> ctl_q.sh;
  assign im_sh  = im_i >>> ctl_q.sh;
  assign load_o = !ctl_q.en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_IDLE;
      cos_q <= '0;
      sin_q <= '0;
      re_q  <= '0;
      im_q  <= '0;
    end else begin
      ctl_q <= ctl_i;
      cos_q <= cos_i;
      sin_q <= sin_i;
      if (load_o) begin
        re_q <= re_sh;
        im_q <= im_sh;
      end
    end
  end

  assign ctl_o = ctl_q;
  assign re_o  = re_q;
  assign im_o  = im_q;
  assign cos_o = cos_q;
  assign sin_o = sin_q;

endmodule

// File: rtl/cmac_core.sv
module cmac_core #(
  parameter int IN_W      = 19,
  parameter int TRIG_W    = 16,
  parameter int ACC_W     = 24,
  parameter int ACC_SHIFT = 17,
  localparam int PROD_W   = IN_W + TRIG_W + 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           acc_mode_i,
  input  logic signed [IN_W-1:0]         re_i,
  input  logic signed [IN_W-1:0]         im_i,
  input  logic signed [TRIG_W-1:0]       cos_i,
  input  logic signed [TRIG_W-1:0]       sin_i,
  output logic [1:0][PROD_W-1:0]         prd_h_o,
  output logic [1:0][ACC_W-1:0]          acc_o,
  output logic [1:0][ACC_W-1:0]          acc_h_o
);

  logic signed [PROD_W-1:0] rc, is, rs, ic;
  logic signed [PROD_W-1:0] prod_c [2];

  assign rc = PROD_W'(re_i) * PROD_W'(cos_i);
  assign is = PROD_W'(im_i) * PROD_W'(sin_i);
  assign rs = PROD_W'(re_i) * PROD_W'(sin_i);
  assign ic = PROD_W'(im_i) * PROD_W'(cos_i);

  assign prod_c[0] = rc - is;
  assign prod_c[1] = rs + ic;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic signed [PROD_W-1:0] prd_q;
    logic signed [ACC_W-1:0]  acc_q, hold_q, term;

    assign term = ACC_W'(prd_q >>> ACC_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prd_q  <= '0;
        acc_q  <= '0;
        hold_q <= '0;
      end else begin
        prd_q <= prod_c[k];
        acc_q <= (acc_mode_i ? acc_q : '0) + term;
        if (!acc_mode_i) hold_q <= acc_q;
      end
    end

    assign prd_h_o[k] = prd_q;
    assign acc_o[k]   = acc_q;
    assign acc_h_o[k] = hold_q;
  end

endmodule

// File: rtl/cmac_peak_det.sv
module cmac_peak_det
  import cmac_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int PROD_W  = 36,
  parameter int ACC_GLO = 15,
  parameter int PRD_GLO = 30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   peak_i,
  input  logic [1:0][ACC_W-1:0]  acc_h_i,
  input  logic [1:0][PROD_W-1:0] prd_h_i,
  output logic [1:0]             cur_o,
  output logic                   track_o,
  output logic [1:0]             det_o
);

  logic [1:0] code_a [2];
  logic [1:0] code_p [2];
  logic [1:0] det_q;
  logic       trk_q;

  for (genvar k = 0; k < 2; k++) begin : g_code
    assign code_a[k] = grow4(acc_h_i[k][ACC_W-1],  acc_h_i[k][ACC_GLO+3:ACC_GLO]);
    assign code_p[k] = grow4(prd_h_i[k][PROD_W-1], prd_h_i[k][PRD_GLO+3:PRD_GLO]);
  end

  assign cur_o = max2(max2(code_a[0], code_a[1]), max2(code_p[0], code_p[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      det_q <= '0;
      trk_q <= 1'b0;
    end else begin
      trk_q <= peak_i;
      det_q <= (peak_i && trk_q) ? max2(det_q, cur_o) : cur_o;
    end
  end

  assign track_o = trk_q;
  assign det_o   = det_q;

endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
  import cmac_pkg::*;
#(
  parameter int IN_W      = 19,
  parameter int TRIG_W    = 16,
  parameter int ACC_W     = 24,
  parameter int ACC_SHIFT = 17,
  parameter int OUT_W     = 20,
  parameter int ACC_GLO   = 15,
  parameter int PRD_GLO   = 30,
  localparam int PROD_W   = IN_W + TRIG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TRIG_W-1:0] cos_i,
  input  logic [TRIG_W-1:0] sin_i,
  input  logic [IN_W-1:0]   re_i,
  input  logic [IN_W-1:0]   im_i,
  input  logic              en_n_i,
  input  logic [1:0]        shift_i,
  input  logic              acc_i,
  input  logic              peak_i,
  input  logic              fmt_i,
  input  logic [1:0]        sel_i,
  output logic [OUT_W-1:0]  re_o,
  output logic [OUT_W-1:0]  im_o,
  output logic [1:0]        grow_o
);

  ctl_t                     ctl_in, ctl_w;
  logic                     load_w;
  logic signed [IN_W-1:0]   in_re_w, in_im_w;
  logic signed [TRIG_W-1:0] cos_w, sin_w;
  logic [1:0][PROD_W-1:0]   prd_h_w;
  logic [1:0][ACC_W-1:0]    acc_w, acc_h_w;
  logic [1:0]               cur_w, det_w;
  logic                     track_w;
  logic [1:0][OUT_W-1:0]    pick_w;
  logic [1:0][OUT_W-1:0]    out_q;

  assign ctl_in = '{en_n: en_n_i, sh: shift_i, acc: acc_i,
                    peak: peak_i, fmt: fmt_i, sel: sel_i};

  cmac_in_stage #(.IN_W(IN_W), .TRIG_W(TRIG_W)) u_in (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_in),
    .re_i(re_i), .im_i(im_i), .cos_i(cos_i), .sin_i(sin_i),
    .ctl_o(ctl_w), .load_o(load_w),
    .re_o(in_re_w), .im_o(in_im_w), .cos_o(cos_w), .sin_o(sin_w)
  );

  cmac_core #(.IN_W(IN_W), .TRIG_W(TRIG_W), .ACC_W(ACC_W), .ACC_SHIFT(ACC_SHIFT)) u_core (
    .clk(clk), .rst_n(rst_n), .acc_mode_i(ctl_w.acc),
    .re_i(in_re_w), .im_i(in_im_w), .cos_i(cos_w), .sin_i(sin_w),
    .prd_h_o(prd_h_w), .acc_o(acc_w), .acc_h_o(acc_h_w)
  );

  cmac_peak_det #(.ACC_W(ACC_W), .PROD_W(PROD_W), .ACC_GLO(ACC_GLO), .PRD_GLO(PRD_GLO)) u_det (
    .clk(clk), .rst_n(rst_n), .peak_i(ctl_w.peak),
    .acc_h_i(acc_h_w), .prd_h_i(prd_h_w),
    .cur_o(cur_w), .track_o(track_w), .det_o(det_w)
  );

  // output select and format per lane (0 = real, 1 = imaginary)
  for (genvar k = 0; k < 2; k++) begin : g_out
    logic [OUT_W-1:0] raw;
    always_comb begin
      unique case (ctl_w.sel)
        2'd0:    raw = acc_h_w[k][ACC_W-1 -: OUT_W];
        2'd1:    raw = prd_h_w[k][PROD_W-1 -: OUT_W];
        2'd2:    raw = prd_h_w[k][OUT_W-1:0];
        default: raw = acc_h_w[k][OUT_W-1:0];
      endcase
    end
    assign pick_w[k] = {raw[OUT_W-1] ^ ~ctl_w.fmt, raw[OUT_W-2:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= pick_w;
  end

  assign re_o   = out_q[0];
  assign im_o   = out_q[1];
  assign grow_o = det_w;

endmodule

// File: rtl/cmac_unit_chk.sv
module cmac_unit_chk #(
  parameter int IN_W  = 19,
  parameter int ACC_W = 24
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   load,
  input logic [IN_W-1:0]        in_re,
  input logic [IN_W-1:0]        in_im,
  input logic                   acc_mode,
  input logic [1:0][ACC_W-1:0]  acc,
  input logic [1:0][ACC_W-1:0]  acc_h,
  input logic                   peak_en,
  input logic                   tracking,
  input logic [1:0]             cur,
  input logic [1:0]             det
);

  p_in_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(in_re) && $stable(in_im)));

  p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mode |=> $stable(acc_h));

  p_dump_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_mode |=> (acc_h == $past(acc)));

  p_det_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_en |=> (det == $past(cur)));

  p_peak_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_en && !tracking) |=> (det == $past(cur)));

  p_peak_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (peak_en && tracking) |=> (det >= $past(det) && det >= $past(cur)));

endmodule

bind cmac_unit cmac_unit_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load_w),
  .in_re(in_re_w), .in_im(in_im_w),
  .acc_mode(ctl_w.acc), .acc(acc_w), .acc_h(acc_h_w),
  .peak_en(ctl_w.peak), .tracking(track_w), .cur(cur_w), .det(det_w)
);

// File: tb/test_cmac_unit.sv
module test_cmac_unit;

  localparam int HALF = 10;  // 50 MHz

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cos_i = '0, sin_i = '0;
  logic [18:0] re_i = '0, im_i = '0;
  logic        en_n_i = 1'b1, acc_i = 1'b1, peak_i = 1'b0, fmt_i = 1'b1;
  logic [1:0]  shift_i = '0, sel_i = '0;
  logic [19:0] re_o, im_o;
  logic [1:0]  grow_o;

  always #HALF clk = ~clk;

  cmac_unit #(.IN_W(19), .TRIG_W(16), .ACC_W(24), .ACC_SHIFT(17), .OUT_W(20),
              .ACC_GLO(15), .PRD_GLO(30)) i_cmac_unit (
    .clk(clk), .rst_n(rst_n), .cos_i(cos_i), .sin_i(sin_i), .re_i(re_i), .im_i(im_i),
    .en_n_i(en_n_i), .shift_i(shift_i), .acc_i(acc_i), .peak_i(peak_i), .fmt_i(fmt_i),
    .sel_i(sel_i), .re_o(re_o), .im_o(im_o), .grow_o(grow_o)
  );

  typedef struct {
    logic [19:0] re;
    logic [19:0] im;
    logic [1:0]  det;
    string       req;
  } item_t;

  item_t q[$];
  int    n_vec = 0, n_bad = 0;
  string phase = "R9";
  bit    done = 1'b0;

  // reference model state
  logic               m_en_n, m_acc, m_peak, m_fmt, m_trk;
  logic [1:0]         m_sh, m_sel, m_det;
  logic signed [18:0] m_re, m_im;
  logic signed [15:0] m_cos, m_sin;
  logic signed [35:0] m_pr [2];
  logic signed [23:0] m_ac [2], m_ah [2];

  function automatic logic [1:0] ref_grow(input logic s, input logic [3:0] n);
    if ((n[3] ^ s) || (n[2] ^ s)) return 2'd3;
    if (n[1] ^ s) return 2'd2;
    if (n[0] ^ s) return 2'd1;
    return 2'd0;
  endfunction

  function automatic logic [19:0] ref_pick(input logic [1:0] sel, input logic fmt,
                                           input logic signed [35:0] pr,
                                           input logic signed [23:0] ah);
    logic [19:0] v;
    case (sel)
      2'd0:    v = 20'(longint'(ah) >>> 4);
      2'd1:    v = 20'(longint'(pr) >>> 16);
      2'd2:    v = 20'(longint'(pr));
      default: v = 20'(longint'(ah));
    endcase
    if (!fmt) v[19] = ~v[19];
    return v;
  endfunction

  always @(posedge clk) begin
    item_t it;
    if (!rst_n) begin
      m_en_n = 1; m_acc = 1; m_peak = 0; m_fmt = 1; m_sh = 0; m_sel = 0;
      m_trk = 0; m_det = 0; m_re = 0; m_im = 0; m_cos = 0; m_sin = 0;
      for (int k = 0; k < 2; k++) begin m_pr[k] = 0; m_ac[k] = 0; m_ah[k] = 0; end
      it.re = '0; it.im = '0; it.det = '0; it.req = "R9";
    end else begin
      logic signed [35:0] n_pr [2];
      logic signed [23:0] n_ac [2], n_ah [2];
      logic [1:0] cur, g, n_det;
      longint a, b;
      cur = 0;
      for (int k = 0; k < 2; k++) begin
        g = ref_grow(m_ah[k][23], m_ah[k][18:15]);
        if (g > cur) cur = g;
        g = ref_grow(m_pr[k][35], m_pr[k][33:30]);
        if (g > cur) cur = g;
      end
      n_det = (m_peak && m_trk && m_det > cur) ? m_det : cur;
      it.re = ref_pick(m_sel, m_fmt, m_pr[0], m_ah[0]);
      it.im = ref_pick(m_sel, m_fmt, m_pr[1], m_ah[1]);
      it.det = n_det;
      it.req = phase;
      a = longint'(m_re) * m_cos - longint'(m_im) * m_sin;
      b = longint'(m_re) * m_sin + longint'(m_im) * m_cos;
      n_pr[0] = 36'(a); n_pr[1] = 36'(b);
      for (int k = 0; k < 2; k++) begin
        n_ac[k] = (m_acc ? m_ac[k] : 24'sd0) + 24'(longint'(m_pr[k]) >>> 17);
        n_ah[k] = m_acc ? m_ah[k] : m_ac[k];
      end
      if (!m_en_n) begin
        m_re = $signed(re_i) >>> m_sh;
        m_im = $signed(im_i) >>> m_sh;
      end
      m_cos = $signed(cos_i); m_sin = $signed(sin_i);
      for (int k = 0; k < 2; k++) begin m_pr[k] = n_pr[k]; m_ac[k] = n_ac[k]; m_ah[k] = n_ah[k]; end
      m_det = n_det; m_trk = m_peak;
      m_en_n = en_n_i; m_sh = shift_i; m_acc = acc_i; m_peak = peak_i;
      m_fmt = fmt_i; m_sel = sel_i;
    end
    q.push_back(it);
  end

  // monitor
  always @(negedge clk) begin
    if (!done && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      n_vec++;
      if (re_o !== e.re || im_o !== e.im || grow_o !== e.det) begin
        n_bad++;
        $display("FAIL %s: re=%h im=%h grow=%0d expected re=%h im=%h grow=%0d",
                 e.req, re_o, im_o, grow_o, e.re, e.im, e.det);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  task automatic drive(input logic en_n, input logic [1:0] sh, input logic acc,
                       input logic pk, input logic fmt, input logic [1:0] sel,
                       input bit big);
    @(negedge clk);
    en_n_i = en_n; shift_i = sh; acc_i = acc; peak_i = pk; fmt_i = fmt; sel_i = sel;
    cos_i = 16'($urandom); sin_i = 16'($urandom);
    re_i = 19'($urandom); im_i = 19'($urandom);
    if (big) begin
      cos_i = {1'b0, 15'h7F00 | 15'($urandom)};
      sin_i = {1'b1, 15'($urandom) & 15'h00FF};
      re_i  = {1'b0, 18'h3F000 | 18'($urandom)};
      im_i  = {1'b1, 18'($urandom) & 18'h00FFF};
    end
  endtask

  initial begin
    #(2 * HALF * 200000);
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    n_bad++;
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs cleared in reset
    n_vec++;
    if (re_o !== '0 || im_o !== '0 || grow_o !== '0) begin
      n_bad++;
      $display("FAIL R9: re=%h im=%h grow=%0d expected 0 0 0", re_o, im_o, grow_o);
    end
    rst_n = 1'b1;
    phase = "R1";
    for (int i = 0; i < 200; i++) drive(1'($urandom), 2'd0, 1'b0, 1'b0, 1'b1, 2'($urandom_range(1, 2)), 0);
    phase = "R2";
    for (int i = 0; i < 200; i++) drive(1'b0, 2'($urandom), 1'b0, 1'b0, 1'b1, 2'd2, 0);
    phase = "R3";
    for (int i = 0; i < 200; i++) drive(1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 2'($urandom_range(1, 2)), 0);
    phase = "R4";
    for (int i = 0; i < 400; i++) drive(1'b0, 2'($urandom), (i % 13) != 0, 1'b0, 1'b1, (i < 200) ? 2'd0 : 2'd3, 0);
    phase = "R5";
    for (int i = 0; i < 200; i++) drive(1'($urandom), 2'($urandom), 1'($urandom), 1'b0, 1'b1, 2'($urandom), 0);
    phase = "R6";
    for (int i = 0; i < 200; i++) drive(1'b0, 2'd0, (i % 7) != 0, 1'b0, 1'($urandom), 2'($urandom), 0);
    phase = "R7";
    for (int i = 0; i < 300; i++) drive(1'b0, 2'($urandom), (i % 9) != 0, 1'b0, 1'b1, 2'($urandom), (i % 3) == 0);
    phase = "R8";
    for (int i = 0; i < 400; i++) drive(1'($urandom), 2'($urandom), (i % 11) != 0, (i % 60) >= 12, 1'b1,
                                        2'($urandom), (i % 60) < 8 || (i % 17) == 0);
    phase = "R8";
    repeat (4) drive(1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 0);
    finish_run();
  end

endmodule